// File: doc/BRIEF.md
# Processor Power-Down Sequencer

This block takes a running processor subsystem down to a powered-off, held-in-reset state with a fixed, ordered sequence. A one-cycle start pulse first raises a bus-halt request toward an external handshake block and waits for its completion. The sequencer then gates the core clock and walks a 32-bit power-control image through its clamp and retention steps. After that it switches off a vector of memory-bank power enables one bank at a time, with a millisecond gap after each bank, and finally drops the block head switch.

The head switch is confirmed off by polling a status input once per millisecond, up to a bounded number of reads. If the status never falls, the error flag is raised and the sequence stops without touching the resets. On success the subsystem reset is asserted, then the core reset, and a one-cycle done pulse marks completion. Microsecond and millisecond timing come from two prescalers, each counted in system clocks, that run only while the sequencer is waiting.

Top module: `core_pwrdown_seq`

## Requirements
- R1: A start pulse seen while idle raises `halt_req_o` on the next cycle. `halt_req_o` stays high until `halt_done_i` is sampled high, and no other output changes during that time.
- R2: On the edge that samples `halt_done_i` high, `halt_req_o` drops and `core_clk_en_o` clears. On the next edge `pwr_ctl_o` bit 20 (IO clamp) sets, and on the edge after that bit 21 (word-line clamp) sets.
- R3: On the edge after R2, `pwr_ctl_o` bit 18 (L2 standby, active low) clears. On the following edge bit 19 (retention, active low) clears.
- R4: `mem_bank_pwr_o` bits are cleared one per step in ascending order from bit 0 to bit NB-1. Each clear is followed by a wait of exactly MS_DIV cycles, and no two bits change on the same edge.
- R5: On the edge after the last bank wait, `pwr_ctl_o` bit 22 (memory clamp) sets. On the next edge bit 24 (head switch on) clears, and a wait of exactly US_DIV cycles follows before the first status read.
- R6: `hs_stat_i` is read once, then every MS_DIV+1 cycles, up to MAX_POLLS reads. If the last allowed read is still high, `err_o` sets on that edge, the resets stay low and the block returns to idle.
- R7: On the edge where a read sees `hs_stat_i` low, `ss_rst_o` sets. On the next edge `core_rst_o` sets.
- R8: `done_o` is high for exactly the one cycle in which `core_rst_o` first appears. `err_o` stays high until the next accepted start, and is cleared on the same edge that raises `halt_req_o`.
- R9: After reset the outputs are as follows: `halt_req_o`=0, `core_clk_en_o`=1, `pwr_ctl_o`=32'h010C0000 (bits 18, 19 and 24 set), `mem_bank_pwr_o` all ones, and `ss_rst_o`, `core_rst_o`, `done_o` and `err_o` all 0.
- R10: A start pulse that arrives while a sequence is in progress is ignored. The running sequence keeps its timing and produces one done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin power-down |
| halt_req_o | output | 1 | Bus-halt request toward the handshake block |
| halt_done_i | input | 1 | Handshake block reports that the bus port is halted |
| hs_stat_i | input | 1 | Head-switch status, high while the switch is still on |
| core_clk_en_o | output | 1 | Core clock enable |
| pwr_ctl_o | output | 32 | Power-control image (clamps, retention, head switch) |
| mem_bank_pwr_o | output | NB | Memory-bank power enables, one bit per bank |
| ss_rst_o | output | 1 | Subsystem reset |
| core_rst_o | output | 1 | Core reset |
| done_o | output | 1 | One-cycle pulse on successful completion |
| err_o | output | 1 | Head-switch poll timed out; held until next start |

## Verification
The bench attacks several corner cases:
- A halt handshake that answers immediately and one that answers late. A design that moved on before the acknowledge would gate the clock too early.
- A head switch that never reports off. A poll counter that is off by one would flag the error one read early or one read late, and a missing error path would hang or assert the resets anyway.
- A status that falls before the very first read, and one that falls after several reads. These expose a microsecond or millisecond wait of the wrong length.
- A stray start pulse in the middle of a run, and a restart after an error. A design that re-armed would restart the banks or leave the stale error flag set.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;
  localparam int PC_W       = 32;
  localparam int B_STBY_N   = 18;
  localparam int B_RET_N    = 19;
  localparam int B_IOCLAMP  = 20;
  localparam int B_WLCLAMP  = 21;
  localparam int B_MEMCLAMP = 22;
  localparam int B_HS_ON    = 24;

  typedef enum logic [3:0] {
    S_IDLE, S_HALT, S_IOC, S_WLC, S_STBY, S_RET, S_BANK, S_BWAIT,
    S_MEMC, S_HSOFF, S_USW, S_POLL, S_PWAIT, S_CRST
  } pd_state_t;

  // power-control image of a running subsystem
  function automatic logic [PC_W-1:0] run_image();
    logic [PC_W-1:0] v;
    v = '0;
    v[B_STBY_N] = 1'b1;
    v[B_RET_N]  = 1'b1;
    v[B_HS_ON]  = 1'b1;
    return v;
  endfunction

  // one-hot mask for a bank index
  function automatic logic [63:0] bank_mask(input int unsigned idx);
    logic [63:0] m;
    m = 64'd1 << idx;
    return m;
  endfunction
endpackage

// File: rtl/pd_tick_gen.sv
module pd_tick_gen #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(DIV + 1);
  logic [CW-1:0] cnt;
  logic          at_end;

  assign at_end = (cnt == CW'(DIV - 1));
  assign tick   = run && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (!run)      cnt <= '0;
    else if (at_end)    cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(DIV));
  a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
endmodule

// File: rtl/pd_bank_ctrl.sv
module pd_bank_ctrl #(
  parameter int NB = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          clr_cur,
  input  logic          adv,
  output logic [NB-1:0] bank_o,
  output logic          last
);
  import pdseq_pkg::*;
  localparam int IW = $clog2(NB + 1);
  logic [IW-1:0] idx;
  logic [63:0]   msk;

  assign msk  = bank_mask(32'(idx));
  assign last = (idx == IW'(NB - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= '0;
      bank_o <= '1;
    end else begin
      if (restart)  idx <= '0;
      else if (adv) idx <= idx + 1'b1;
      if (clr_cur)  bank_o <= bank_o & ~msk[NB-1:0];
    end
  end

  a_r4_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bank_o ^ $past(bank_o)) <= 1);
  a_r4_no_power_up: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_o & ~$past(bank_o)) == '0);
endmodule

// File: rtl/core_pwrdown_seq.sv
module core_pwrdown_seq #(
  parameter int NB        = 20,
  parameter int US_DIV    = 100,
  parameter int MS_DIV    = 100000,
  parameter int MAX_POLLS = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          halt_req_o,
  input  logic          halt_done_i,
  input  logic          hs_stat_i,
  output logic          core_clk_en_o,
  output logic [31:0]   pwr_ctl_o,
  output logic [NB-1:0] mem_bank_pwr_o,
  output logic          ss_rst_o,
  output logic          core_rst_o,
  output logic          done_o,
  output logic          err_o
);
  import pdseq_pkg::*;
  localparam int PW = $clog2(MAX_POLLS + 1);

  pd_state_t state;
  logic [PW-1:0] polls;

  // named internal events
  logic ms_run, us_run, ms_tick, us_tick;
  logic bank_restart, bank_clr, bank_adv, bank_last;
  logic poll_ok, poll_expired;

  assign ms_run       = (state == S_BWAIT) || (state == S_PWAIT);
  assign us_run       = (state == S_USW);
  assign bank_restart = (state == S_RET);
  assign bank_clr     = (state == S_BANK);
  assign bank_adv     = (state == S_BWAIT) && ms_tick && !bank_last;
  assign poll_ok      = (state == S_POLL) && !hs_stat_i;
  assign poll_expired = (state == S_POLL) && hs_stat_i && (polls == PW'(MAX_POLLS - 1));

  pd_tick_gen #(.DIV(MS_DIV)) u_ms (.clk(clk), .rst_n(rst_n), .run(ms_run), .tick(ms_tick));
  pd_tick_gen #(.DIV(US_DIV)) u_us (.clk(clk), .rst_n(rst_n), .run(us_run), .tick(us_tick));

  pd_bank_ctrl #(.NB(NB)) u_bank (
    .clk(clk), .rst_n(rst_n), .restart(bank_restart), .clr_cur(bank_clr),
    .adv(bank_adv), .bank_o(mem_bank_pwr_o), .last(bank_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      halt_req_o    <= 1'b0;
      core_clk_en_o <= 1'b1;
      pwr_ctl_o     <= run_image();
      ss_rst_o      <= 1'b0;
      core_rst_o    <= 1'b0;
      done_o        <= 1'b0;
      err_o         <= 1'b0;
      polls         <= '0;
    end else begin
      done_o <= 1'b0;
      case (state)
        S_IDLE: if (start_i) begin
          err_o      <= 1'b0;
          halt_req_o <= 1'b1;
          state      <= S_HALT;
        end
        S_HALT: if (halt_done_i) begin
          halt_req_o    <= 1'b0;
          core_clk_en_o <= 1'b0;
          state         <= S_IOC;
        end
        S_IOC:   begin pwr_ctl_o[B_IOCLAMP]  <= 1'b1; state <= S_WLC;  end
        S_WLC:   begin pwr_ctl_o[B_WLCLAMP]  <= 1'b1; state <= S_STBY; end
        S_STBY:  begin pwr_ctl_o[B_STBY_N]   <= 1'b0; state <= S_RET;  end
        S_RET:   begin pwr_ctl_o[B_RET_N]    <= 1'b0; state <= S_BANK; end
        S_BANK:  state <= S_BWAIT;
        S_BWAIT: if (ms_tick) state <= bank_last ? S_MEMC : S_BANK;
        S_MEMC:  begin pwr_ctl_o[B_MEMCLAMP] <= 1'b1; state <= S_HSOFF; end
        S_HSOFF: begin pwr_ctl_o[B_HS_ON]    <= 1'b0; state <= S_USW;   end
        S_USW:   if (us_tick) begin polls <= '0; state <= S_POLL; end
        S_POLL: begin
          if (poll_ok) begin
            ss_rst_o <= 1'b1;
            state    <= S_CRST;
          end else if (poll_expired) begin
            err_o <= 1'b1;
            state <= S_IDLE;
          end else begin
            polls <= polls + 1'b1;
            state <= S_PWAIT;
          end
        end
        S_PWAIT: if (ms_tick) state <= S_POLL;
        S_CRST: begin
          core_rst_o <= 1'b1;
          done_o     <= 1'b1;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1: request held until the handshake answers
  a_r1_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req_o && !halt_done_i) |=> halt_req_o);
  // R2: clock gating only follows a completed halt
  a_r2_clk_after_halt: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_clk_en_o) |-> $past(halt_done_i));
  // R6: an error only follows a status read that was still high
  a_r6_err_from_poll: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> $past(hs_stat_i));
  // R7: subsystem reset is already in place when core reset rises
  a_r7_rst_order: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst_o) |-> ss_rst_o);
  // R8: done lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: tb/core_pwrdown_seq_tb_top.sv
`timescale 1ns/1ps
module core_pwrdown_seq_tb_top;
  localparam int NB = 20;
  localparam int US = 3;
  localparam int MS = 12;
  localparam int NP = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic halt_done_i = 1'b0;
  logic hs_stat_i = 1'b1;
  logic halt_req_o, core_clk_en_o, ss_rst_o, core_rst_o, done_o, err_o;
  logic [31:0] pwr_ctl_o;
  logic [NB-1:0] mem_bank_pwr_o;

  always #5 clk = ~clk;

  core_pwrdown_seq #(.NB(NB), .US_DIV(US), .MS_DIV(MS), .MAX_POLLS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .halt_req_o(halt_req_o),
    .halt_done_i(halt_done_i), .hs_stat_i(hs_stat_i), .core_clk_en_o(core_clk_en_o),
    .pwr_ctl_o(pwr_ctl_o), .mem_bank_pwr_o(mem_bank_pwr_o), .ss_rst_o(ss_rst_o),
    .core_rst_o(core_rst_o), .done_o(done_o), .err_o(err_o)
  );

  int checks = 0;
  int fails = 0;
  int halt_lat = 3;
  int hs_lat = 30;
  bit hs_stuck = 1'b0;
  int hcnt = 0;
  int scnt = 0;
  int done_cnt = 0;

  // expected outputs
  logic e_halt, e_clk, e_ss, e_core, e_done, e_err;
  logic [31:0] e_pwr;
  logic [NB-1:0] e_bank;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic set_reset_expect();
    e_halt = 0; e_clk = 1; e_ss = 0; e_core = 0; e_done = 0; e_err = 0;
    e_pwr = 32'h0100_0000 | 32'h0008_0000 | 32'h0004_0000;
    e_bank = '1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    set_reset_expect();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_end();
    int n;
    n = 0;
    while (!done_o && !err_o && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // halt handshake model
  always @(negedge clk) begin
    if (!halt_req_o) begin
      hcnt = 0;
      halt_done_i = 1'b0;
    end else begin
      if (hcnt >= halt_lat) halt_done_i = 1'b1;
      hcnt++;
    end
  end

  // head-switch model
  always @(negedge clk) begin
    if (hs_stuck) hs_stat_i = 1'b1;
    else if (pwr_ctl_o[24]) begin
      hs_stat_i = 1'b1;
      scnt = 0;
    end else begin
      hs_stat_i = (scnt < hs_lat);
      scnt++;
    end
  end

  always @(negedge clk) if (rst_n && done_o) done_cnt++;

  // behavioural reference model, advanced at each rising edge
  initial begin : ref_model
    logic st, a, h;
    set_reset_expect();
    forever begin
      forever begin
        @(posedge clk); st = start_i && rst_n; #1;
        e_done = 1'b0;
        if (st) break;
      end
      e_err = 1'b0; e_halt = 1'b1;
      forever begin
        @(posedge clk); a = halt_done_i; #1;
        if (a) break;
      end
      e_halt = 1'b0; e_clk = 1'b0;
      @(posedge clk); #1 e_pwr[20] = 1'b1;
      @(posedge clk); #1 e_pwr[21] = 1'b1;
      @(posedge clk); #1 e_pwr[18] = 1'b0;
      @(posedge clk); #1 e_pwr[19] = 1'b0;
      for (int b = 0; b < NB; b++) begin
        @(posedge clk); #1 e_bank[b] = 1'b0;
        repeat (MS) @(posedge clk);
      end
      @(posedge clk); #1 e_pwr[22] = 1'b1;
      @(posedge clk); #1 e_pwr[24] = 1'b0;
      repeat (US) @(posedge clk);
      for (int n = 1; n <= NP; n++) begin
        @(posedge clk); h = hs_stat_i; #1;
        if (!h) begin
          e_ss = 1'b1;
          @(posedge clk); #1 e_core = 1'b1; e_done = 1'b1;
          break;
        end
        if (n == NP) begin
          e_err = 1'b1;
          break;
        end
        repeat (MS) @(posedge clk);
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      check(halt_req_o == e_halt, "R1 halt_req", 64'(halt_req_o), 64'(e_halt));
      check(core_clk_en_o == e_clk, "R2 clk_en", 64'(core_clk_en_o), 64'(e_clk));
      check(pwr_ctl_o[21:20] == e_pwr[21:20], "R2 clamps", 64'(pwr_ctl_o[21:20]), 64'(e_pwr[21:20]));
      check(pwr_ctl_o[19:18] == e_pwr[19:18], "R3 retention", 64'(pwr_ctl_o[19:18]), 64'(e_pwr[19:18]));
      check(mem_bank_pwr_o == e_bank, "R4 banks", 64'(mem_bank_pwr_o), 64'(e_bank));
      check(pwr_ctl_o[24:22] == e_pwr[24:22], "R5 memclamp/headswitch", 64'(pwr_ctl_o[24:22]), 64'(e_pwr[24:22]));
      check(err_o == e_err, "R6 err", 64'(err_o), 64'(e_err));
      check({ss_rst_o, core_rst_o} == {e_ss, e_core}, "R7 resets", 64'({ss_rst_o, core_rst_o}), 64'({e_ss, e_core}));
      check(done_o == e_done, "R8 done", 64'(done_o), 64'(e_done));
      check(pwr_ctl_o == e_pwr, "R9 image", 64'(pwr_ctl_o), 64'(e_pwr));
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R9: reset state
    check(pwr_ctl_o == 32'h010C0000, "R9 reset image", 64'(pwr_ctl_o), 64'h010C0000);
    check(mem_bank_pwr_o == '1, "R9 reset banks", 64'(mem_bank_pwr_o), 64'(20'hFFFFF));
    check({halt_req_o, ss_rst_o, core_rst_o, done_o, err_o} == 5'b0 && core_clk_en_o,
          "R9 reset controls", 64'({halt_req_o, ss_rst_o, core_rst_o, done_o, err_o, core_clk_en_o}), 64'h1);

    // A: late halt ack, a few polls, stray start mid-run (R10)
    halt_lat = 3; hs_lat = 30; hs_stuck = 0; done_cnt = 0;
    pulse_start();
    repeat (40) @(negedge clk);
    pulse_start();
    wait_end();
    repeat (5) @(negedge clk);
    check(done_cnt == 1, "R10 single done", 64'(done_cnt), 64'd1);
    check(core_rst_o && ss_rst_o && !err_o, "R7 final resets", 64'({ss_rst_o, core_rst_o, err_o}), 64'b110);

    // B: switch never reports off, then retry (R6, R8)
    do_reset();
    hs_stuck = 1;
    pulse_start();
    wait_end();
    @(negedge clk);
    check(err_o && !ss_rst_o && !core_rst_o, "R6 timeout error", 64'({err_o, ss_rst_o, core_rst_o}), 64'b100);
    repeat (20) @(negedge clk);
    check(err_o == 1'b1, "R8 error held", 64'(err_o), 64'd1);
    hs_stuck = 0; hs_lat = 0; done_cnt = 0;
    pulse_start();
    check(err_o == 1'b0, "R8 error cleared on start", 64'(err_o), 64'd0);
    wait_end();
    repeat (3) @(negedge clk);
    check(done_cnt == 1, "R7 retry completes", 64'(done_cnt), 64'd1);

    // C: immediate halt ack, switch off before first read
    do_reset();
    halt_lat = 0; hs_lat = 0; done_cnt = 0;
    pulse_start();
    wait_end();
    repeat (3) @(negedge clk);
    check(done_cnt == 1 && core_rst_o, "R7 fast path", 64'({done_cnt[3:0], core_rst_o}), 64'h3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule